// File: doc/BRIEF.md
# Data Watchpoint Comparator Bank

This block holds a small bank of data-address watchpoint units for a processor debug block. Each unit keeps an address register and a control register. Debug software programs the units through an indexed register write port and reads them back through a combinational read port. A fixed identification word reports how many watchpoint and breakpoint register pairs the debug block has.

The core presents every load or store it performs on an access stream. Each access is compared in parallel against all units. A unit matches when all of these hold:

- it is enabled;
- its privilege filter admits the access;
- its load/store filter admits the access;
- the word address is equal;
- at least one byte lane it selects is touched by the access.

One cycle later the bank reports a registered hit together with the index of the lowest-numbered matching unit.

The access stream uses a valid/ready pair. The bank never applies back-pressure: `acc_ready` is always high. Every cycle in which `acc_valid` is high counts as one accepted access, and it produces exactly one hit/no-hit result on the next cycle. The register ports and the hit outputs are plain signals with no handshake.

Top module: `wpt_bank`

## Requirements
- R1: A unit whose control bit 0 (enable) is clear never produces a hit, whatever its other fields hold. Writing zero to a control register disables that unit.
- R2: Control bit 1 admits privileged accesses (`acc_priv`=1) and control bit 2 admits user accesses (`acc_priv`=0). An access whose privilege level is not admitted does not hit.
- R3: Control bit 3 admits loads (`acc_write`=0) and control bit 4 admits stores (`acc_write`=1). An access whose type is not admitted does not hit.
- R4: Control bits 8:5 select byte lanes 0..3, with lane n at bit 5+n. The lanes an access touches depend on `acc_size` and `acc_addr[1:0]`:
  - `acc_size`=0 (byte): lane addr[1:0].
  - `acc_size`=1 (halfword): lanes addr[1:0] and addr[1:0]+1, where a lane beyond 3 is dropped.
  - `acc_size`=2 or 3 (word): all four lanes.
  
  A hit needs at least one lane that is both selected and touched.
- R5: Only address bits 31:2 are compared. The address register stores bits 31:2, and bits 1:0 read back as zero.
- R6: A control register keeps only bits 8:0. All other control bits read back as zero.
- R7: After reset every address and control register reads zero, and no hit is reported.
- R8: `hit_valid` and `hit_idx` are registered and appear in the cycle after an accepted access. With no access, `hit_valid`=0 and `hit_idx`=0. `acc_ready` is always 1.
- R9: When several units match the same access, `hit_idx` reports the lowest index among them.
- R10: Register index 16+i addresses watchpoint unit i (`wr_sel`/`rd_sel` 0 = address register, 1 = control register). Writes to indices 0..15 or to indices beyond the last unit are ignored, and reads from those indices return zero.
- R11: `id_word` bits 31:28 hold NUM_WP-1, bits 27:24 hold NUM_BP-1, and all other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register pair index for the write |
| wr_sel | input | 1 | 0 = address register, 1 = control register |
| wr_data | input | 32 | Write data |
| rd_idx | input | 5 | Register pair index for the read |
| rd_sel | input | 1 | 0 = address register, 1 = control register |
| rd_data | output | 32 | Read data (combinational) |
| id_word | output | 32 | Unit-count identification word |
| acc_valid | input | 1 | Access stream valid |
| acc_ready | output | 1 | Access stream ready (always 1) |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| hit_valid | output | 1 | Registered watchpoint hit |
| hit_idx | output | IDXW | Lowest matching unit index |

## Verification
The bench places two units on the same word, with different lane selections and type filters. A word store touching both must report the lower index; a priority encoder that scans the wrong way would report unit 1. Byte and halfword accesses land on unselected lanes of a watched word, which catches a design that compares plain word addresses and ignores lane overlap. Separate accesses differ only in privilege or only in load/store type, which exposes swapped filter bits. A fully configured unit with only the enable bit clear must stay silent. Writes to breakpoint indices and to the low address bits must leave nothing behind on readback, which catches decoding that aliases the two index halves.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int CTRL_W = 9;
  localparam int LANES  = 4;

  // control field positions
  localparam int C_EN    = 0;
  localparam int C_PRIV  = 1;
  localparam int C_USER  = 2;
  localparam int C_LOAD  = 3;
  localparam int C_STORE = 4;
  localparam int C_LANE0 = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/wpt_lane_decode.sv
module wpt_lane_decode
  import wpt_pkg::*;
(
  input  logic [1:0]       offs,
  input  logic [1:0]       size,
  output logic [LANES-1:0] lanes
);
  logic [LANES-1:0] base;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: base = 4'b0001;
      SZ_HALF: base = 4'b0011;
      default: base = 4'b1111;
    endcase
    lanes = (size[1]) ? 4'b1111 : (base << offs);
  end
endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
  import wpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_val,
  input  logic              wr_ctrl,
  input  logic [31:0]       wdata,
  input  logic [31:2]       acc_word,
  input  logic [LANES-1:0]  acc_lanes,
  input  logic              acc_write,
  input  logic              acc_priv,
  output logic [31:2]       val_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              enabled,
  output logic              match
);
  logic priv_ok, type_ok, lane_ok, addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_val)  val_q  <= wdata[31:2];
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    priv_ok = acc_priv  ? ctrl_q[C_PRIV]  : ctrl_q[C_USER];
    type_ok = acc_write ? ctrl_q[C_STORE] : ctrl_q[C_LOAD];
    lane_ok = |(ctrl_q[C_LANE0 +: LANES] & acc_lanes);
    addr_ok = (val_q == acc_word);
    enabled = ctrl_q[C_EN];
    match   = enabled & priv_ok & type_ok & lane_ok & addr_ok;
  end

  // R7: a register written nothing since reset stays zero right after reset
  p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !$past(wr_ctrl)) |-> ctrl_q == '0);
endmodule

// File: rtl/wpt_prio.sv
module wpt_prio #(
  parameter int N    = 4,
  parameter int IDXW = 2
) (
  input  logic [N-1:0]    req,
  output logic            any,
  output logic [IDXW-1:0] idx,
  output logic [N-1:0]    grant
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDXW'(i);
        grant = N'(1) << i;
        any   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wpt_bank.sv
module wpt_bank
  import wpt_pkg::*;
#(
  parameter int NUM_WP = 4,
  parameter int NUM_BP = 6,
  localparam int IDXW = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic            wr_sel,
  input  logic [31:0]     wr_data,
  input  logic [4:0]      rd_idx,
  input  logic            rd_sel,
  output logic [31:0]     rd_data,
  output logic [31:0]     id_word,
  input  logic            acc_valid,
  output logic            acc_ready,
  input  logic [31:0]     acc_addr,
  input  logic [1:0]      acc_size,
  input  logic            acc_write,
  input  logic            acc_priv,
  output logic            hit_valid,
  output logic [IDXW-1:0] hit_idx
);
  localparam int WP_BASE = 16;

  logic [LANES-1:0]  lanes;
  logic [NUM_WP-1:0] match_vec, en_vec, grant;
  logic [31:2]       val_arr  [NUM_WP];
  logic [CTRL_W-1:0] ctrl_arr [NUM_WP];
  logic              any_match;
  logic [IDXW-1:0]   win_idx;

  assign acc_ready = 1'b1;
  assign id_word   = {4'(NUM_WP-1), 4'(NUM_BP-1), 24'd0};

  wpt_lane_decode u_lanes (
    .offs  (acc_addr[1:0]),
    .size  (acc_size),
    .lanes (lanes)
  );

  for (genvar g = 0; g < NUM_WP; g++) begin : g_unit
    logic sel_here;
    assign sel_here = wr_en && (wr_idx == 5'(WP_BASE + g));
    wpt_unit u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_val    (sel_here && !wr_sel),
      .wr_ctrl   (sel_here && wr_sel),
      .wdata     (wr_data),
      .acc_word  (acc_addr[31:2]),
      .acc_lanes (lanes),
      .acc_write (acc_write),
      .acc_priv  (acc_priv),
      .val_q     (val_arr[g]),
      .ctrl_q    (ctrl_arr[g]),
      .enabled   (en_vec[g]),
      .match     (match_vec[g])
    );
  end

  wpt_prio #(.N(NUM_WP), .IDXW(IDXW)) u_prio (
    .req   (match_vec),
    .any   (any_match),
    .idx   (win_idx),
    .grant (grant)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_WP; i++) begin
      if (rd_idx == 5'(WP_BASE + i))
        rd_data = rd_sel ? {{(32-CTRL_W){1'b0}}, ctrl_arr[i]} : {val_arr[i], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_idx   <= '0;
    end else begin
      hit_valid <= acc_valid && any_match;
      hit_idx   <= (acc_valid && any_match) ? win_idx : '0;
    end
  end

  // R8: a hit only follows an accepted access
  p_hit_after_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(acc_valid));
  // R8: idle result carries index zero
  p_idle_index_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid |-> hit_idx == '0);
  // R1: a reported hit came from an enabled, matching unit
  p_hit_from_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> ($past(en_vec & match_vec) != '0));
  // R9: the winner is a single unit
  p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: tb/wpt_bank_tb_top.sv
module wpt_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [4:0] wr_idx = 0, rd_idx = 0;
  logic [31:0] wr_data = 0, rd_data, id_word;
  logic acc_valid = 0, acc_ready, acc_write = 0, acc_priv = 0;
  logic [31:0] acc_addr = 0;
  logic [1:0] acc_size = 0;
  logic hit_valid;
  logic [1:0] hit_idx;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wpt_bank dut_i (.*);

  // {addr, size, write, priv, exp_hit, exp_idx}
  localparam logic [39:0] VEC [12] = '{
    {32'h1000, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0},
    {32'h1001, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0},
    {32'h1002, 2'd1, 1'b1, 1'b0, 1'b1, 3'd1},
    {32'h1000, 2'd2, 1'b1, 1'b0, 1'b1, 3'd0},
    {32'h1002, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0},
    {32'h2000, 2'd2, 1'b0, 1'b1, 1'b1, 3'd2},
    {32'h2000, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0},
    {32'h2003, 2'd0, 1'b1, 1'b1, 1'b0, 3'd0},
    {32'h2003, 2'd0, 1'b0, 1'b1, 1'b1, 3'd2},
    {32'h3000, 2'd2, 1'b0, 1'b1, 1'b0, 3'd0},
    {32'h1004, 2'd2, 1'b1, 1'b0, 1'b0, 3'd0},
    {32'h1003, 2'd0, 1'b1, 1'b0, 1'b1, 3'd1}
  };
  localparam string VTAG [12] = '{"R4", "R4", "R4", "R9", "R3", "R2",
                                  "R2", "R3", "R4", "R1", "R5", "R4"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] idx, input logic sel, output logic [31:0] d);
    rd_idx = idx; rd_sel = sel;
    #1 d = rd_data;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] s, input logic w,
                        input logic p, input logic v, output logic h, output logic [2:0] ix);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size = s; acc_write = w; acc_priv = p;
    @(negedge clk);
    h = hit_valid; ix = {1'b0, hit_idx};
    acc_valid = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic h;
    logic [2:0] ix;
    repeat (3) @(negedge clk);
    // reset state, R7
    rd(5'd16, 1'b1, r); chk("R7 ctrl after reset", r, 0);
    rd(5'd17, 1'b0, r); chk("R7 value after reset", r, 0);
    chk("R7 hit after reset", {31'd0, hit_valid}, 0);
    rst_n = 1;
    chk("R11 id word", id_word, {4'd3, 4'd5, 24'd0});
    chk("R8 ready", {31'd0, acc_ready}, 1);

    // program units
    wr(5'd16, 0, 32'h1000); wr(5'd16, 1, 32'h03F);
    wr(5'd17, 0, 32'h1000); wr(5'd17, 1, 32'h197);
    wr(5'd18, 0, 32'h2003); wr(5'd18, 1, 32'h1EB);
    wr(5'd19, 0, 32'h3000); wr(5'd19, 1, 32'h1FE);

    rd(5'd18, 0, r); chk("R5 low address bits dropped", r, 32'h2000);
    rd(5'd17, 1, r); chk("R10 control readback", r, 32'h197);

    foreach (VEC[k]) begin
      access(VEC[k][39:8], VEC[k][7:6], VEC[k][5], VEC[k][4], 1'b1, h, ix);
      chk({VTAG[k], " vector hit"}, {31'd0, h}, {31'd0, VEC[k][3]});
      chk({VTAG[k], " vector idx"}, {29'd0, ix}, {29'd0, VEC[k][2:0]});
    end

    // R8: no access, no hit even when the address would match
    access(32'h1000, 2'd0, 0, 0, 1'b0, h, ix);
    chk("R8 idle hit", {31'd0, h}, 0);
    chk("R8 idle idx", {29'd0, ix}, 0);

    // R10: breakpoint index and out-of-range index ignored
    wr(5'd2, 1, 32'h1FF);
    rd(5'd2, 1, r); chk("R10 breakpoint index read", r, 0);
    wr(5'd20, 1, 32'h1FF);
    rd(5'd20, 1, r); chk("R10 out-of-range read", r, 0);
    rd(5'd16, 1, r); chk("R10 unit0 untouched", r, 32'h03F);

    // R6: upper control bits dropped
    wr(5'd19, 1, 32'hFFFF_FE00);
    rd(5'd19, 1, r); chk("R6 control upper bits", r, 0);

    // R1: clearing control disables unit 0
    wr(5'd16, 1, 32'h0);
    access(32'h1000, 2'd0, 0, 0, 1'b1, h, ix);
    chk("R1 disabled unit", {31'd0, h}, 0);

    // R7: reset clears programmed units
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    rd(5'd17, 1, r); chk("R7 ctrl cleared by reset", r, 0);
    rst_n = 1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule